// File: doc/BRIEF.md
# Second-Aligned Timing Pulse Generator

This block drives a once-per-second timing pulse whose rising edge follows a second-boundary strobe from the timing logic by one clock cycle. The pulse stays high for a fixed number of milliseconds. A fixed number of milliseconds after each rising edge, the block raises a one-cycle strobe. The message path uses that strobe to queue its time report for the second just marked.

After a boundary strobe has aligned the block, an internal phase counter keeps it running. If later boundary strobes go missing, the pulse train continues at the nominal one-second period. The next strobe that arrives restarts the phase. While the time solution is not valid, or while the device is in a low-power state, both outputs stay low and the alignment is dropped. A fresh boundary strobe is then needed before pulses resume.

The clock rate (ticks per millisecond), the period, the high time and the strobe delay are parameters, so a test build can shrink the second to a few thousand cycles.

Top module: `pps_gen`

## Requirements
- R1: After reset, and until the first accepted boundary strobe, `pps_o` and `msg_stb_o` are both 0.
- R2: A boundary strobe sampled high on a clock edge while enabled (`time_valid_i`=1 and `low_power_i`=0) makes `pps_o` read 1 right after that edge, so the rising edge lags the boundary by one cycle.
- R3: Each pulse is high for exactly HIGH_MS*TICKS_PER_MS consecutive cycles, unless a new boundary strobe restarts the phase.
- R4: `msg_stb_o` is high for exactly one cycle, MSG_MS*TICKS_PER_MS cycles after the cycle in which `pps_o` rose, once per period.
- R5: Without further boundary strobes, the block free-runs: each rising edge follows the previous one by PERIOD_MS*TICKS_PER_MS cycles.
- R6: A boundary strobe accepted at any phase restarts the phase at zero, so the next rise follows it by one cycle (re-alignment).
- R7: While `time_valid_i` is 0, both outputs are 0 in the same cycle, boundary strobes are ignored, and alignment is lost. Pulses resume only after a later accepted strobe.
- R8: While `low_power_i` is 1, both outputs are 0 in the same cycle, boundary strobes are ignored, and alignment is lost, as for R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| epoch_i | input | 1 | One-cycle second-boundary strobe |
| time_valid_i | input | 1 | Time solution valid |
| low_power_i | input | 1 | Device is in a low-power state |
| pps_o | output | 1 | Once-per-second timing pulse |
| msg_stb_o | output | 1 | One-cycle strobe to queue the time message |

## Verification
The pulse is due one clock edge after an accepted boundary strobe. The strobe is due MSG_MS*TICKS_PER_MS cycles after the rise, and the next free-running rise is due PERIOD_MS*TICKS_PER_MS cycles after the last one. Gating by `time_valid_i` or `low_power_i` takes effect in the same cycle.

A reference model in the bench counts cycles since the last accepted strobe, updates on every rising edge and is compared with both outputs 1 ns after the edge. Further checks measure the high time, the strobe offset and the period by counting falling edges from the observed rise.

// File: rtl/pps_pkg.sv
package pps_pkg;
  function automatic int unsigned ms_to_cyc(input int unsigned ticks_per_ms,
                                            input int unsigned ms);
    return ticks_per_ms * ms;
  endfunction
endpackage

// File: rtl/pps_phase_ctr.sv
module pps_phase_ctr #(
  parameter int unsigned PERIOD_CYC = 1000,
  localparam int unsigned CW = $clog2(PERIOD_CYC)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enable_i,
  input  logic          epoch_i,
  output logic          active_o,
  output logic [CW-1:0] phase_o
);
  localparam logic [CW-1:0] LAST = CW'(PERIOD_CYC - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      phase_o  <= '0;
    end else if (!enable_i) begin
      // alignment is lost while gated
      active_o <= 1'b0;
      phase_o  <= '0;
    end else if (epoch_i) begin
      active_o <= 1'b1;
      phase_o  <= '0;
    end else if (active_o) begin
      phase_o  <= (phase_o == LAST) ? '0 : phase_o + 1'b1;
    end
  end
endmodule

// File: rtl/pps_out_dec.sv
module pps_out_dec #(
  parameter int unsigned PERIOD_CYC = 1000,
  parameter int unsigned HIGH_CYC   = 200,
  parameter int unsigned STB_CYC    = 300,
  localparam int unsigned CW = $clog2(PERIOD_CYC)
) (
  input  logic          enable_i,
  input  logic          active_i,
  input  logic [CW-1:0] phase_i,
  output logic          pps_o,
  output logic          stb_o
);
  localparam logic [CW-1:0] HIGH_LIM = CW'(HIGH_CYC);
  localparam logic [CW-1:0] STB_AT   = CW'(STB_CYC);

  always_comb begin
    pps_o = enable_i && active_i && (phase_i < HIGH_LIM);
    stb_o = enable_i && active_i && (phase_i == STB_AT);
  end
endmodule

// File: rtl/pps_gen.sv
module pps_gen #(
  parameter int unsigned TICKS_PER_MS = 200000,
  parameter int unsigned PERIOD_MS    = 1000,
  parameter int unsigned HIGH_MS      = 200,
  parameter int unsigned MSG_MS       = 300
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic epoch_i,
  input  logic time_valid_i,
  input  logic low_power_i,
  output logic pps_o,
  output logic msg_stb_o
);
  import pps_pkg::*;

  localparam int unsigned PERIOD_CYC = ms_to_cyc(TICKS_PER_MS, PERIOD_MS);
  localparam int unsigned HIGH_CYC   = ms_to_cyc(TICKS_PER_MS, HIGH_MS);
  localparam int unsigned STB_CYC    = ms_to_cyc(TICKS_PER_MS, MSG_MS);
  localparam int unsigned CW         = $clog2(PERIOD_CYC);

  logic          enable;
  logic          active;
  logic [CW-1:0] phase;

  assign enable = time_valid_i && !low_power_i;

  pps_phase_ctr #(.PERIOD_CYC(PERIOD_CYC)) u_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .enable_i (enable),
    .epoch_i  (epoch_i),
    .active_o (active),
    .phase_o  (phase)
  );

  pps_out_dec #(
    .PERIOD_CYC (PERIOD_CYC),
    .HIGH_CYC   (HIGH_CYC),
    .STB_CYC    (STB_CYC)
  ) u_dec (
    .enable_i (enable),
    .active_i (active),
    .phase_i  (phase),
    .pps_o    (pps_o),
    .stb_o    (msg_stb_o)
  );
endmodule

// File: rtl/pps_gen_chk.sv
module pps_gen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic epoch_i,
  input logic time_valid_i,
  input logic low_power_i,
  input logic pps_o,
  input logic msg_stb_o
);
  a_r2_epoch_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (epoch_i && time_valid_i && !low_power_i) |=> (pps_o || !time_valid_i || low_power_i));

  a_r4_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_stb_o |=> !msg_stb_o);

  a_r4_strobe_after_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_stb_o |-> !pps_o);

  a_r7_invalid_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !time_valid_i |-> (!pps_o && !msg_stb_o));

  a_r8_low_power_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_power_i |-> (!pps_o && !msg_stb_o));

  a_r3_no_glitch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(pps_o) && time_valid_i && !low_power_i) |=>
      (pps_o || !time_valid_i || low_power_i));
endmodule

bind pps_gen pps_gen_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .epoch_i      (epoch_i),
  .time_valid_i (time_valid_i),
  .low_power_i  (low_power_i),
  .pps_o        (pps_o),
  .msg_stb_o    (msg_stb_o)
);

// File: tb/pps_gen_bench.sv
`timescale 1ns/1ps
module pps_gen_bench;
  localparam int TPM    = 4;
  localparam int PERIOD = 1000 * TPM;
  localparam int HIGH   = 200 * TPM;
  localparam int STB    = 300 * TPM;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic epoch = 1'b0;
  logic valid = 1'b1;
  logic lp = 1'b0;
  logic pps, stb;

  int vectors = 0;
  int errors = 0;
  int cycles = 0;
  string req_tag = "R1";
  bit done = 0;

  // reference model state
  bit ref_act = 0;
  longint ref_t = 0;

  always #2.5 clk = ~clk;

  pps_gen #(.TICKS_PER_MS(TPM)) u_pps_gen (
    .clk_i(clk), .rst_ni(rst_n), .epoch_i(epoch), .time_valid_i(valid),
    .low_power_i(lp), .pps_o(pps), .msg_stb_o(stb)
  );

  task automatic chk(input string tag, input logic act, input logic exp, input string what);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit en;
    bit e_pps, e_stb;
    cycles++;
    en = valid && !lp;
    if (!rst_n) begin ref_act = 0; ref_t = 0; end
    else if (!en) ref_act = 0;
    else if (epoch) begin ref_act = 1; ref_t = 0; end
    else if (ref_act) ref_t++;
    #1;
    en = valid && !lp;
    e_pps = en && ref_act && ((ref_t % PERIOD) < HIGH);
    e_stb = en && ref_act && ((ref_t % PERIOD) == STB);
    if (!done) begin
      chk(req_tag, pps, e_pps, "pps_o vs model");
      chk({req_tag, "/R4"}, stb, e_stb, "msg_stb_o vs model");
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic fire_epoch;
    epoch = 1'b1;
    @(negedge clk);
    epoch = 1'b0;
  endtask

  // measure one period starting at an observed rise (current negedge)
  task automatic measure_period;
    int fall_at = -1, stb_at = -1, rise_at = -1, stb_cnt = 0;
    logic prev = pps;
    for (int i = 1; i <= PERIOD; i++) begin
      @(negedge clk);
      if (prev && !pps && fall_at < 0) fall_at = i;
      if (stb) begin stb_cnt++; if (stb_at < 0) stb_at = i; end
      if (!prev && pps && rise_at < 0) rise_at = i;
      prev = pps;
    end
    chk("R3", logic'(fall_at == HIGH), 1'b1, $sformatf("high time %0d", fall_at));
    chk("R4", logic'(stb_at == STB), 1'b1, $sformatf("strobe offset %0d", stb_at));
    chk("R4", logic'(stb_cnt == 1), 1'b1, $sformatf("strobe count %0d", stb_cnt));
    chk("R5", logic'(rise_at == PERIOD), 1'b1, $sformatf("period %0d", rise_at));
  endtask

  initial begin
    cyc(4);
    chk("R1", pps, 1'b0, "pps_o in reset");
    chk("R1", stb, 1'b0, "msg_stb_o in reset");
    rst_n = 1'b1;
    cyc(200);
    chk("R1", pps, 1'b0, "pps_o unaligned");

    req_tag = "R2";
    fire_epoch();
    chk("R2", pps, 1'b1, "pps_o one cycle after boundary");
    req_tag = "R5";
    measure_period();
    measure_period();

    // re-align mid period and during the high phase
    req_tag = "R6";
    cyc(2500);
    fire_epoch();
    chk("R6", pps, 1'b1, "rise after late boundary");
    cyc(300);
    fire_epoch();
    chk("R6", pps, 1'b1, "restart in high phase");
    measure_period();

    // invalid time
    req_tag = "R7";
    cyc(100);
    valid = 1'b0;
    #0.1;
    chk("R7", pps, 1'b0, "pps_o gated by invalid");
    cyc(50);
    fire_epoch();
    chk("R7", pps, 1'b0, "boundary ignored while invalid");
    cyc(50);
    valid = 1'b1;
    cyc(PERIOD + 300);
    chk("R7", pps, 1'b0, "no pulse until new boundary");
    fire_epoch();
    chk("R7", pps, 1'b1, "resume after boundary");
    cyc(1100);

    // low power
    req_tag = "R8";
    lp = 1'b1;
    #0.1;
    chk("R8", stb, 1'b0, "msg_stb_o gated by low power");
    chk("R8", pps, 1'b0, "pps_o gated by low power");
    cyc(40);
    fire_epoch();
    chk("R8", pps, 1'b0, "boundary ignored in low power");
    lp = 1'b0;
    cyc(PERIOD + 200);
    chk("R8", pps, 1'b0, "still unaligned after wake");
    fire_epoch();
    chk("R8", pps, 1'b1, "resume after wake and boundary");
    measure_period();
    cyc(10);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    wait (cycles >= 150000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule